// File: doc/BRIEF.md
# Banked Scratchpad Conflict Arbiter

This block is the access path to a scratchpad built from sixteen word-wide banks. A batch of up to sixteen lane requests arrives at once. Each lane carries a word address, a read or write flag, write data, and a bit in an active mask. The low address bits pick the bank and the rest pick the row inside it. Lanes whose accesses fall in different banks are all served in the same cycle. Lanes that meet in one bank at different words are spread over later cycles. Reads of one word, and writes of one word, are merged into a single bank access.

The block takes a batch only while it is idle. It holds `busy_o` high for every cycle in which it still serves lanes of that batch. Each lane reports completion with a one-cycle pulse, and a read lane returns its data in the same cycle as that pulse. The number of service cycles equals the largest number of separate accesses that any one bank must make. A stride-1 pattern or any one-to-one lane-to-bank permutation therefore takes one cycle. A stride of 2 takes two cycles, a stride of 8 takes eight, and a stride of 16 takes sixteen.

Top module: `sp_conflict_arb`

## Requirements
- R1: A word address selects bank = address[3:0] and row = address[9:4]. A word written at an address is returned by a later read of that address.
- R2: When `req_valid_i` is high while `busy_o` is low, the batch is captured at the clock edge. A request presented while `busy_o` is high is ignored and does not change which lanes complete or the data they return.
- R3: A batch whose active lanes all map to distinct banks is served in one cycle, so `busy_o` is high for exactly one cycle.
- R4: A batch whose active lanes all read one word is served in one cycle by broadcast, and every active lane returns that word.
- R5: The number of cycles with `busy_o` high equals, taken over all banks, the largest count of distinct (row, read/write) groups among the active lanes mapped to that bank.
- R6: In each cycle, each bank serves the pending lane with the lowest index. In that same cycle it also serves every other pending lane that targets the same word with the same read/write flag. A read served before a write to its word returns the old value.
- R7: When several lanes write one word in the same cycle, the lane with the highest index determines the stored value.
- R8: A lane served in cycle k pulses `lane_done_o` in cycle k+1, and `rdata_o` for a read lane is valid during that pulse. `busy_o` stays high through the last service cycle and drops in the cycle after it.
- R9: After reset, `busy_o` is low and `lane_done_o` is all zero.
- R10: A lane whose mask bit is clear never completes. A batch with an all-zero mask leaves `busy_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Batch present; taken only while idle |
| req_mask_i | input | 16 | Active lane mask |
| req_we_i | input | 16 | Per-lane write flag (1 = write) |
| req_addr_i | input | 16x10 | Per-lane word address |
| req_wdata_i | input | 16x32 | Per-lane write data |
| busy_o | output | 1 | Batch still being served; new requests are refused |
| lane_done_o | output | 16 | Per-lane completion pulse |
| rdata_o | output | 16x32 | Per-lane read data, valid with the lane's completion pulse |

## Verification
The assertions assume that a batch is taken only when the block is idle, and that an idle cycle produces no completion pulse. They also assume that every busy cycle retires at least one pending lane, so the scheduling rule must always make progress. The bench drives junk requests with `req_valid_i` high during every busy cycle. It drops `req_valid_i` in the first idle cycle, so only intended batches are captured. It fills all rows with writes before any read, so every read has a defined expected value. The random batches draw addresses from a small window, which makes bank conflicts, shared words and mixed read/write groups frequent.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int unsigned SP_LANES  = 16;
  localparam int unsigned SP_BANKS  = 16;
  localparam int unsigned SP_DATA_W = 32;
  localparam int unsigned SP_ADDR_W = 10;
endpackage

// File: rtl/sp_bank_sched.sv
// Per-bank pick: lowest pending lane leads, same word and same direction join it.
module sp_bank_sched #(
  parameter int unsigned LANES  = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ROW_W  = 6
) (
  input  logic [LANES-1:0]             cand_i,
  input  logic [LANES-1:0]             we_i,
  input  logic [LANES-1:0][ROW_W-1:0]  row_i,
  input  logic [LANES-1:0][DATA_W-1:0] wdata_i,
  output logic [LANES-1:0]             grant_o,
  output logic                         acc_valid_o,
  output logic                         acc_we_o,
  output logic [ROW_W-1:0]             acc_row_o,
  output logic [DATA_W-1:0]            acc_wdata_o
);
  localparam int unsigned LIDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [LIDX_W-1:0] lead;
  logic              found;

  always_comb begin
    lead  = '0;
    found = 1'b0;
    for (int l = 0; l < int'(LANES); l++) begin
      if (cand_i[l] && !found) begin
        lead  = LIDX_W'(l);
        found = 1'b1;
      end
    end
  end

  assign acc_valid_o = found;
  assign acc_we_o    = we_i[lead];
  assign acc_row_o   = row_i[lead];

  always_comb begin
    grant_o     = '0;
    acc_wdata_o = '0;
    for (int l = 0; l < int'(LANES); l++) begin
      grant_o[l] = cand_i[l] && (row_i[l] == row_i[lead]) && (we_i[l] == we_i[lead]);
      if (grant_o[l]) acc_wdata_o = wdata_i[l]; // highest granted lane wins
    end
  end
endmodule

// File: rtl/sp_bank_ram.sv
module sp_bank_ram #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ROW_W  = 6
) (
  input  logic              clk_i,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned ROWS = 1 << ROW_W;

  logic [DATA_W-1:0] mem [ROWS];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) mem[row_i] <= wdata_i;
      else      rdata_q    <= mem[row_i];
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/sp_conflict_arb.sv
module sp_conflict_arb
  import sp_pkg::*;
#(
  parameter int unsigned LANES  = SP_LANES,
  parameter int unsigned BANKS  = SP_BANKS,
  parameter int unsigned DATA_W = SP_DATA_W,
  parameter int unsigned ADDR_W = SP_ADDR_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_valid_i,
  input  logic [LANES-1:0]             req_mask_i,
  input  logic [LANES-1:0]             req_we_i,
  input  logic [LANES-1:0][ADDR_W-1:0] req_addr_i,
  input  logic [LANES-1:0][DATA_W-1:0] req_wdata_i,
  output logic                         busy_o,
  output logic [LANES-1:0]             lane_done_o,
  output logic [LANES-1:0][DATA_W-1:0] rdata_o
);
  localparam int unsigned BANK_W = $clog2(BANKS);
  localparam int unsigned ROW_W  = ADDR_W - BANK_W;

  logic [LANES-1:0]             pend_q, we_q, done_q, grant_all;
  logic [LANES-1:0][ADDR_W-1:0] addr_q;
  logic [LANES-1:0][DATA_W-1:0] wdata_q;
  logic [LANES-1:0][BANK_W-1:0] lane_bank;
  logic [LANES-1:0][ROW_W-1:0]  lane_row;
  logic [BANKS-1:0][LANES-1:0]  grant_b;
  logic [BANKS-1:0][DATA_W-1:0] bank_rd;
  logic                         accept;

  assign busy_o = |pend_q;
  assign accept = req_valid_i && !busy_o;

  always_comb begin
    for (int l = 0; l < int'(LANES); l++) begin
      lane_bank[l] = addr_q[l][BANK_W-1:0];
      lane_row[l]  = addr_q[l][ADDR_W-1:BANK_W];
    end
  end

  for (genvar b = 0; b < int'(BANKS); b++) begin : g_bank
    logic [LANES-1:0]  cand;
    logic              acc_valid, acc_we;
    logic [ROW_W-1:0]  acc_row;
    logic [DATA_W-1:0] acc_wdata;

    always_comb begin
      for (int l = 0; l < int'(LANES); l++)
        cand[l] = pend_q[l] && (lane_bank[l] == BANK_W'(b));
    end

    sp_bank_sched #(.LANES(LANES), .DATA_W(DATA_W), .ROW_W(ROW_W)) u_sched (
      .cand_i      (cand),
      .we_i        (we_q),
      .row_i       (lane_row),
      .wdata_i     (wdata_q),
      .grant_o     (grant_b[b]),
      .acc_valid_o (acc_valid),
      .acc_we_o    (acc_we),
      .acc_row_o   (acc_row),
      .acc_wdata_o (acc_wdata)
    );

    sp_bank_ram #(.DATA_W(DATA_W), .ROW_W(ROW_W)) u_ram (
      .clk_i   (clk_i),
      .en_i    (acc_valid),
      .we_i    (acc_we),
      .row_i   (acc_row),
      .wdata_i (acc_wdata),
      .rdata_o (bank_rd[b])
    );
  end

  always_comb begin
    grant_all = '0;
    for (int b = 0; b < int'(BANKS); b++) grant_all |= grant_b[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      done_q <= '0;
    end else begin
      done_q <= grant_all;
      if (accept) pend_q <= req_mask_i;
      else        pend_q <= pend_q & ~grant_all;
    end
  end

  always_ff @(posedge clk_i) begin
    if (accept) begin
      we_q    <= req_we_i;
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
    end
  end

  assign lane_done_o = done_q;

  // batch registers stay stable while completions are visible
  always_comb begin
    for (int l = 0; l < int'(LANES); l++) rdata_o[l] = bank_rd[lane_bank[l]];
  end
endmodule

// File: rtl/sp_arb_checker.sv
module sp_arb_checker #(
  parameter int unsigned LANES = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [LANES-1:0] req_mask_i,
  input logic             busy_o,
  input logic [LANES-1:0] lane_done_o,
  input logic [LANES-1:0] pend_q
);
  a_r2_accept_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_o) |=> (pend_q == $past(req_mask_i)));

  a_r5_progress: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (((pend_q & ~$past(pend_q)) == '0) && (pend_q != $past(pend_q))));

  a_r8_done_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (lane_done_o == ($past(pend_q) & ~pend_q)));

  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> (lane_done_o == '0));
endmodule

bind sp_conflict_arb sp_arb_checker #(.LANES(LANES)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_mask_i  (req_mask_i),
  .busy_o      (busy_o),
  .lane_done_o (lane_done_o),
  .pend_q      (pend_q)
);

// File: tb/test_sp_conflict_arb.sv
module test_sp_conflict_arb;
  localparam int CLK_P = 10;
  localparam int NL = 16;

  logic                 clk = 1'b0;
  logic                 rst_ni = 1'b0;
  logic                 req_valid_i = 1'b0;
  logic [NL-1:0]        req_mask_i = '0;
  logic [NL-1:0]        req_we_i = '0;
  logic [NL-1:0][9:0]   req_addr_i = '0;
  logic [NL-1:0][31:0]  req_wdata_i = '0;
  logic                 busy_o;
  logic [NL-1:0]        lane_done_o;
  logic [NL-1:0][31:0]  rdata_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [31:0] model_mem [1024];
  logic [NL-1:0] b_mask, b_we;
  logic [9:0]    b_addr  [NL];
  logic [31:0]   b_wdata [NL];

  sp_conflict_arb i_sp_conflict_arb (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_mask_i(req_mask_i),
    .req_we_i(req_we_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .busy_o(busy_o), .lane_done_o(lane_done_o), .rdata_o(rdata_o)
  );

  initial forever #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive_junk();
    req_valid_i = 1'b1;
    req_mask_i  = 16'($urandom);
    req_we_i    = 16'($urandom);
    for (int l = 0; l < NL; l++) begin
      req_addr_i[l]  = 10'($urandom);
      req_wdata_i[l] = $urandom;
    end
  endtask

  // exp_n < 0: cycle count not pinned by the test
  task automatic run_batch(input int exp_n, input string req);
    logic [NL-1:0] sched [NL];
    logic [NL-1:0] pend, g;
    int n, busy_cnt, lead;
    pend = b_mask;
    n = 0;
    while (pend != 0 && n < NL) begin
      g = '0;
      for (int b = 0; b < 16; b++) begin
        lead = -1;
        for (int l = 0; l < NL; l++)
          if (pend[l] && b_addr[l][3:0] == 4'(b) && lead < 0) lead = l;
        if (lead >= 0)
          for (int l = 0; l < NL; l++)
            if (pend[l] && b_addr[l] == b_addr[lead] && b_we[l] == b_we[lead]) g[l] = 1'b1;
      end
      sched[n] = g;
      pend &= ~g;
      n++;
    end

    @(negedge clk);
    req_valid_i = 1'b1;
    req_mask_i  = b_mask;
    req_we_i    = b_we;
    for (int l = 0; l < NL; l++) begin
      req_addr_i[l]  = b_addr[l];
      req_wdata_i[l] = b_wdata[l];
    end
    @(negedge clk);
    busy_cnt = 0;
    check(busy_o == (n > 0), "R10", "busy after accept", 32'(busy_o), 32'(n > 0));
    check(lane_done_o == '0, "R8", "done in first cycle", 32'(lane_done_o), 0);
    if (busy_o) busy_cnt++;
    if (n > 0) drive_junk();  // R2: ignored while busy
    else req_valid_i = 1'b0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      check(lane_done_o == sched[k-1], req, "done set", 32'(lane_done_o), 32'(sched[k-1]));
      for (int l = 0; l < NL; l++)
        if (sched[k-1][l] && !b_we[l])
          check(rdata_o[l] === model_mem[b_addr[l]], "R1", $sformatf("rdata lane %0d", l),
                rdata_o[l], model_mem[b_addr[l]]);
      for (int l = 0; l < NL; l++)
        if (sched[k-1][l] && b_we[l]) model_mem[b_addr[l]] = b_wdata[l];
      check(busy_o == (k < n), "R8", "busy level", 32'(busy_o), 32'(k < n));
      if (busy_o) busy_cnt++;
      if (k == n) req_valid_i = 1'b0;
      else drive_junk();
    end
    if (exp_n >= 0)
      check(busy_cnt == exp_n, req, "busy cycles", 32'(busy_cnt), 32'(exp_n));
  endtask

  task automatic clear_batch();
    b_mask = '0;
    b_we   = '0;
    for (int l = 0; l < NL; l++) begin
      b_addr[l]  = '0;
      b_wdata[l] = '0;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    if (!finished) $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(busy_o == 1'b0, "R9", "busy after reset", 32'(busy_o), 0);
    check(lane_done_o == '0, "R9", "done after reset", 32'(lane_done_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 R3: fill every word with stride-1 writes
    for (int base = 0; base < 1024; base += 16) begin
      clear_batch();
      b_mask = '1; b_we = '1;
      for (int l = 0; l < NL; l++) begin
        b_addr[l]  = 10'(base + l);
        b_wdata[l] = $urandom;
      end
      run_batch(1, "R3");
    end

    clear_batch();
    b_mask = '1;
    for (int l = 0; l < NL; l++) b_addr[l] = 10'(32 + l);
    run_batch(1, "R3");

    clear_batch();
    b_mask = '1;
    for (int l = 0; l < NL; l++) b_addr[l] = 10'(480 + ((l * 5 + 3) % 16));
    run_batch(1, "R3");

    clear_batch();
    b_mask = '1;
    for (int l = 0; l < NL; l++) b_addr[l] = 10'd77;
    run_batch(1, "R4");

    clear_batch();
    b_mask = '1;
    for (int l = 0; l < NL; l++) b_addr[l] = 10'(l * 2);
    run_batch(2, "R5");

    clear_batch();
    b_mask = '1;
    for (int l = 0; l < NL; l++) b_addr[l] = 10'(l * 8);
    run_batch(8, "R5");

    clear_batch();
    b_mask = '1;
    for (int l = 0; l < NL; l++) b_addr[l] = 10'(l * 16);
    run_batch(16, "R5");

    // R6: lanes 0 and 2 share a word and go first
    clear_batch();
    b_mask = 16'h000f;
    b_addr[0] = 10'd0; b_addr[1] = 10'd16; b_addr[2] = 10'd0; b_addr[3] = 10'd32;
    run_batch(3, "R6");

    // R7: three writers to one word, then read back
    clear_batch();
    b_mask = 16'h1088; b_we = 16'h1088;
    for (int l = 0; l < NL; l++) begin
      b_addr[l]  = 10'd200;
      b_wdata[l] = 32'hA000_0000 + 32'(l);
    end
    run_batch(1, "R7");
    clear_batch();
    b_mask = 16'h0001; b_addr[0] = 10'd200;
    run_batch(1, "R7");
    check(model_mem[200] == 32'hA000_000C, "R7", "winner value", model_mem[200], 32'hA000_000C);

    // R6: read before write on one word returns old value
    clear_batch();
    b_mask = 16'h0003; b_we = 16'h0002;
    b_addr[0] = 10'd300; b_addr[1] = 10'd300; b_wdata[1] = 32'h1234_5678;
    run_batch(2, "R6");

    clear_batch();
    b_mask = '0;
    run_batch(0, "R10");

    clear_batch();
    b_mask = 16'h8421;
    for (int l = 0; l < NL; l++) b_addr[l] = 10'(l * 16);
    run_batch(4, "R10");

    for (int t = 0; t < 400; t++) begin
      b_mask = 16'($urandom);
      b_we   = 16'($urandom);
      for (int l = 0; l < NL; l++) begin
        b_addr[l]  = 10'($urandom % 64);
        b_wdata[l] = $urandom;
      end
      run_batch(-1, "R5");
    end

    @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule